// File: doc/BRIEF.md
# Interrupt routing controller

The block collects 32 interrupt source inputs into pending latches and forwards each one to one of six processor interrupt lines. Every source owns a 4-bit setting: three bits pick its destination line and one bit enables it. A line is the registered OR of every source that is pending, enabled and steered to that line. Disabling a source hides it from the lines but keeps its pending state, so enabling it again brings the interrupt back.

Software reaches the block through a simple 32-bit register bus with a word address. Four control words hold the per-source settings. A write-one-to-clear word drops pending bits. A read-only status word returns all pending bits. Level sources that stay asserted cannot be cleared; they simply stay pending.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every control word, the status word and all six lines read zero.
- R2: Source n is set through control word n/8 (word addresses 0 to 3), bits 4*(n%8)+3 down to 4*(n%8). Reading a control word returns every stored bit.
- R3: In a source's setting, bits [2:0] select the line. Codes 0 to 4 drive lines 0 to 4, code 6 drives line 5, and codes 5 and 7 drive no line.
- R4: Bit 3 of a source's setting is its enable. A source whose enable is 0 drives no line.
- R5: A source input that is high at a clock edge sets its pending bit. The bit then stays set, whatever its enable, until it is cleared.
- R6: Writing to word address 4 clears pending bit n for every 1 in bit n of the data. A 0 bit has no effect. A source that is high in the same cycle as the clear stays pending.
- R7: A read of word address 5 returns the 32 pending bits. A read of address 4 returns zero.
- R8: A line rises one clock after a pending, enabled source steered to it appears, and falls one clock after the last such source goes away.
- R9: Writes to word addresses 4 to 7 leave the control words unchanged, and reads of addresses 6 and 7 return zero.
- R10: Several sources steered to the same line combine by OR. The line falls only when none of them is pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw interrupt source inputs, active high |
| we_i | input | 1 | Bus write strobe |
| addr_i | input | 3 | Bus word address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, combinational from addr_i |
| irq_o | output | 6 | Processor interrupt lines, registered |

## Verification
The hardest case to reach is a clear that lands in the same cycle as the source it targets, while that source's setting is also being rewritten. In that case the order of set, clear and enable decides what the lines and the status word show. The bench holds level sources high across clear writes and toggles enables while bits are pending. After the directed phases it runs a long random phase. Sparse random sources are mixed there with random writes to all eight addresses, so clears, setting changes and new assertions overlap. A behavioural reference model is compared with the lines and the read data on every clock.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned LINE_N = 6;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } src_cfg_t;

  // codes 5 and 7 are unused
  function automatic logic [LINE_N-1:0] sel_decode(input logic [SEL_W-1:0] s);
    logic [LINE_N-1:0] r;
    r = '0;
    case (s)
      3'd0: r[0] = 1'b1;
      3'd1: r[1] = 1'b1;
      3'd2: r[2] = 1'b1;
      3'd3: r[3] = 1'b1;
      3'd4: r[4] = 1'b1;
      3'd6: r[5] = 1'b1;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned SRC_N  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [SRC_N/(DATA_W/NIB_W)-1:0][DATA_W-1:0] regs_o,
  output src_cfg_t [SRC_N-1:0]           cfg_o
);
  localparam int unsigned PER_REG = DATA_W / NIB_W;
  localparam int unsigned REG_N   = SRC_N / PER_REG;

  logic [REG_N-1:0][DATA_W-1:0] regs_q;

  for (genvar r = 0; r < REG_N; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[r] <= '0;
      else if (we_i && (int'(addr_i) == r)) regs_q[r] <= wdata_i;
    end
  end

  for (genvar n = 0; n < SRC_N; n++) begin : g_unpack
    assign cfg_o[n] = src_cfg_t'(regs_q[n / PER_REG][(n % PER_REG) * NIB_W +: NIB_W]);
  end

  assign regs_o = regs_q;

  // R9
  undef_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (int'(addr_i) >= REG_N)) |=> $stable(regs_q));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned SRC_N = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] pend_o
);
  logic [SRC_N-1:0] pend_q;

  // assertion wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | src_i;
  end

  assign pend_o = pend_q;

  // R5
  set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(src_i) & ~pend_q) == '0));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q) & ~$past(clr_i) & ~pend_q) == '0));
  // R6
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(clr_i) & ~$past(src_i) & pend_q) == '0));
endmodule

// File: rtl/irq_line_or.sv
module irq_line_or
  import irq_route_pkg::*;
#(
  parameter int unsigned SRC_N = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SRC_N-1:0]      pend_i,
  input  src_cfg_t [SRC_N-1:0]  cfg_i,
  output logic [LINE_N-1:0]     irq_o
);
  logic [SRC_N-1:0] en_vec;
  logic [LINE_N-1:0] line_d;
  logic [LINE_N-1:0] irq_q;
  logic [SRC_N-1:0][LINE_N-1:0] hit;

  for (genvar n = 0; n < SRC_N; n++) begin : g_src
    assign en_vec[n] = cfg_i[n].en;
    assign hit[n]    = (pend_i[n] && cfg_i[n].en) ? sel_decode(cfg_i[n].sel) : '0;
  end

  always_comb begin
    line_d = '0;
    for (int n = 0; n < SRC_N; n++) line_d |= hit[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= line_d;
  end

  assign irq_o = irq_q;

  // R4
  all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_vec == '0) |=> (irq_q == '0));
  // R8
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & en_vec) == '0) |=> (irq_q == '0));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned SRC_N  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  src_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LINE_N-1:0] irq_o
);
  localparam int unsigned PER_REG  = DATA_W / NIB_W;
  localparam int unsigned REG_N    = SRC_N / PER_REG;
  localparam int unsigned CLR_OFS  = REG_N;
  localparam int unsigned STAT_OFS = REG_N + 1;

  logic [REG_N-1:0][DATA_W-1:0] regs;
  src_cfg_t [SRC_N-1:0]         cfg;
  logic [SRC_N-1:0]             pend;
  logic [SRC_N-1:0]             clr_vec;

  assign clr_vec = (we_i && (int'(addr_i) == CLR_OFS)) ? wdata_i[SRC_N-1:0] : '0;

  irq_cfg_regs #(.SRC_N(SRC_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .regs_o(regs), .cfg_o(cfg)
  );

  irq_pend_bank #(.SRC_N(SRC_N)) u_pend (
    .clk_i, .rst_ni, .src_i, .clr_i(clr_vec), .pend_o(pend)
  );

  irq_line_or #(.SRC_N(SRC_N)) u_line (
    .clk_i, .rst_ni, .pend_i(pend), .cfg_i(cfg), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < REG_N)          rdata_o = regs[addr_i[$clog2(REG_N)-1:0]];
    else if (int'(addr_i) == STAT_OFS) rdata_o[SRC_N-1:0] = pend;
  end
endmodule

// File: tb/irq_route_ctrl_bench.sv
`timescale 1ns/1ps
module irq_route_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [5:0]  irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  irq_route_ctrl u_irq_route_ctrl (.*);

  // reference model
  logic [31:0] m_cfg [4];
  logic [31:0] m_pend;
  logic [5:0]  m_irq;

  function automatic int line_of(int code);
    if (code <= 4) return code;
    if (code == 6) return 5;
    return -1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_cfg[i]) m_cfg[i] = '0;
      m_pend = '0;
      m_irq  = '0;
    end else begin : upd
      logic [5:0] nx;
      nx = '0;
      for (int n = 0; n < 32; n++) begin
        int nib;
        nib = (m_cfg[n / 8] >> (4 * (n % 8))) & 15;
        if (m_pend[n] && nib >= 8 && line_of(nib & 7) >= 0) nx[line_of(nib & 7)] = 1'b1;
      end
      if (we_i && addr_i == 3'd4) m_pend = m_pend & ~wdata_i;
      m_pend = m_pend | src_i;
      if (we_i && addr_i < 3'd4) m_cfg[addr_i] = wdata_i;
      m_irq = nx;
    end
  end

  function automatic logic [31:0] m_read(logic [2:0] a);
    if (a < 3'd4) return m_cfg[a];
    if (a == 3'd5) return m_pend;
    return '0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check("R8 R10 irq_o vs model", {26'd0, irq_o}, {26'd0, m_irq});
      check("R2 R7 rdata_o vs model", rdata_o, m_read(addr_i));
    end
  end

  task automatic step(int k = 1);
    repeat (k) begin @(negedge clk_i); #1; end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    step(); we_i = 1'b1; addr_i = a; wdata_i = d;
    step(); we_i = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] exp);
    addr_i = a; #0.5;
    check(tag, rdata_o, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step();
    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 3'(a), 32'h0);
    check("R1 reset irq_o", {26'd0, irq_o}, 32'h0);

    // R2 field layout read-back
    wr(3'd0, 32'hA5C3_1E7F); wr(3'd3, 32'h1234_89AB);
    rd_chk("R2 word0", 3'd0, 32'hA5C3_1E7F);
    rd_chk("R2 word3", 3'd3, 32'h1234_89AB);
    wr(3'd0, 32'h0); wr(3'd3, 32'h0);

    // R3 each code on source 9 (word 1, bits 7:4)
    for (int c = 0; c < 8; c++) begin
      logic [5:0] e;
      e = (line_of(c) >= 0) ? 6'(1 << line_of(c)) : 6'd0;
      wr(3'd1, 32'((8 + c) << 4));
      src_i[9] = 1'b1; step(); src_i[9] = 1'b0;
      step(2);
      check("R3 route code", {26'd0, irq_o}, {26'd0, e});
      wr(3'd4, 32'h200);
      step(2);
      check("R6 cleared irq", {26'd0, irq_o}, 32'h0);
    end

    // R4 disabled keeps pending
    wr(3'd1, 32'h0000_0020);      // source 9, code 2, enable 0
    src_i[9] = 1'b1; step(); src_i[9] = 1'b0; step(2);
    check("R4 disabled no drive", {26'd0, irq_o}, 32'h0);
    rd_chk("R5 pending kept while disabled", 3'd5, 32'h200);
    wr(3'd1, 32'h0000_00A0);
    step(2);
    check("R4 re-enable drives line 2", {26'd0, irq_o}, 32'h4);

    // R10 OR of two sources on line 2 (sources 9 and 17)
    wr(3'd2, 32'h0000_00A0);
    src_i[17] = 1'b1; step(); src_i[17] = 1'b0; step();
    wr(3'd4, 32'h200); step(2);
    check("R10 line held by other source", {26'd0, irq_o}, 32'h4);
    wr(3'd4, 32'h2_0000); step(2);
    check("R10 line falls after last", {26'd0, irq_o}, 32'h0);

    // R6 level held during clear, zeros no effect
    src_i[3] = 1'b1; src_i[20] = 1'b1; step(); src_i[20] = 1'b0;
    wr(3'd4, 32'h0000_0008); step();
    rd_chk("R6 level re-pends", 3'd5, 32'h0010_0008);
    src_i[3] = 1'b0;
    wr(3'd4, 32'h0000_0008); step();
    rd_chk("R6 clear one, zeros ignored", 3'd5, 32'h0010_0000);
    rd_chk("R7 clear word reads zero", 3'd4, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);

    // R9 undefined offsets
    wr(3'd0, 32'h8888_8888);
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'h1234_5678); wr(3'd5, 32'h5555_5555);
    rd_chk("R9 word0 unchanged", 3'd0, 32'h8888_8888);
    rd_chk("R9 read addr6 zero", 3'd6, 32'h0);
    rd_chk("R9 read addr7 zero", 3'd7, 32'h0);

    // random mix, model compared every clock (R5 R6 R8)
    for (int i = 0; i < 4000; i++) begin
      step();
      src_i = $urandom & $urandom & $urandom & $urandom;
      we_i = ($urandom % 3) == 0;
      addr_i = 3'($urandom);
      wdata_i = $urandom;
    end
    we_i = 1'b0; src_i = '0;
    step(3);
    finish_run();
  end
endmodule